// File: doc/BRIEF.md
# Strobed Parallel Handshake Controller

This block holds the status and interrupt flags for two 8-bit parallel ports whose transfers are paced by peripheral pulses. Port A can run in plain mode, in one-direction handshake mode (strobed input or acknowledged output), or in bidirectional mode. Port B can run in plain mode or in one-direction handshake mode. A peripheral strobe captures an incoming byte into a holding register and marks that the input buffer is full. A peripheral acknowledge marks that the byte the CPU wrote has been taken. CPU reads and writes of the data registers clear or raise the matching buffer flags. Each port has an interrupt line. It rises when an event occurs and that event's enable bit is set.

All flags and enables sit at fixed bit positions of a status byte, so other logic can decode them as port C. The strobe and acknowledge lines are asynchronous. Each one is synchronised and edge-detected, so one pulse of any length is exactly one event. When a CPU access and a peripheral event change the same flag in the same cycle, the peripheral event takes priority. For bidirectional port A, an output-enable is also produced: it follows the synchronised acknowledge line. The pin drivers themselves are not part of this block.

Top module: `hsk_port_ctrl`

## Requirements
- R1: After synchronous reset the status byte reads 0x80, both holding registers are 0, both interrupt lines are 0 and the output-enable is 0.
- R2: The status byte layout is: bit 7 output-buffer-full A (low = full), bit 6 enable for acknowledge A, bit 5 input-buffer-full A, bit 4 enable for strobe A, bit 3 interrupt A, bit 2 enable B, bit 1 buffer flag B, bit 0 interrupt B. A pulse on en_wr copies en_val into the bit numbered en_sel when en_sel is 6, 4 or 2. Any other en_sel value leaves the status byte unchanged.
- R3: A strobe A event is honoured when a_mode is 1 (handshake) with a_dir_in=1, or when a_mode is 2 or 3 (bidirectional). It captures pa_in into a_in_q, sets bit 5, and sets bit 3 if bit 4 is set.
- R4: A strobe B event is honoured when b_hs=1 and b_dir_in=1. It captures pb_in into b_in_q, sets bit 1, and sets bit 0 if bit 2 is set.
- R5: cpu_rd_a, when port A is in handshake input or bidirectional mode, clears bit 5. It also clears bit 3, except in bidirectional mode while bit 7 is 0.
- R6: cpu_wr_a, when port A is in handshake output or bidirectional mode, clears bit 7. It also clears bit 3 in handshake output mode, and in bidirectional mode only when bit 5 is 0.
- R7: An acknowledge A event, when port A is in handshake output or bidirectional mode, sets bit 7 and sets bit 3 if bit 6 is set. In bidirectional mode a_oe follows the synchronised acknowledge level. Otherwise a_oe is 1 exactly when a_dir_in is 0.
- R8: With b_hs=1 and b_dir_in=0, cpu_wr_b clears bits 1 and 0, and an acknowledge B event sets bit 1 (and bit 0 if bit 2 is set). With b_hs=1 and b_dir_in=1, cpu_rd_b clears bits 1 and 0.
- R9: Each rising edge of a strobe or acknowledge line is one event, acted on SYNC_STAGES+1 clock edges after the line rises. Holding the line high produces no further event.
- R10: When a peripheral event and a CPU access change the same flag in one cycle, the flag takes the value of the peripheral event.
- R11: Strobes, acknowledges and CPU data accesses that the current mode does not honour change neither the status byte nor the holding registers.
- R12: irq_a always equals bit 3 and irq_b always equals bit 0 of the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_mode | input | 2 | Port A mode: 0 plain, 1 handshake, 2 or 3 bidirectional |
| a_dir_in | input | 1 | Port A direction in plain or handshake mode (1 = input) |
| b_hs | input | 1 | Port B handshake mode enable |
| b_dir_in | input | 1 | Port B direction (1 = input) |
| stb_a | input | 1 | Asynchronous strobe from the peripheral, port A |
| ack_a | input | 1 | Asynchronous acknowledge from the peripheral, port A |
| stb_b | input | 1 | Asynchronous strobe from the peripheral, port B |
| ack_b | input | 1 | Asynchronous acknowledge from the peripheral, port B |
| pa_in | input | DW | Port A pin data, captured on strobe A |
| pb_in | input | DW | Port B pin data, captured on strobe B |
| cpu_rd_a | input | 1 | One-cycle CPU read of port A data |
| cpu_wr_a | input | 1 | One-cycle CPU write of port A data |
| cpu_rd_b | input | 1 | One-cycle CPU read of port B data |
| cpu_wr_b | input | 1 | One-cycle CPU write of port B data |
| en_wr | input | 1 | One-cycle write of a single enable bit |
| en_sel | input | 3 | Status bit position addressed by en_wr |
| en_val | input | 1 | Value written by en_wr |
| stat_c | output | 8 | Status byte (port C flag layout) |
| a_in_q | output | DW | Port A input holding register |
| b_in_q | output | DW | Port B input holding register |
| irq_a | output | 1 | Port A interrupt, active high |
| irq_b | output | 1 | Port B interrupt, active high |
| a_oe | output | 1 | Port A output-enable for the pin drivers |

## Verification
Some properties are checked on every cycle. A buffer-full flag or an interrupt flag may rise only after a qualifying event. A CPU access with no competing event must leave its flag cleared on the next cycle. An acknowledge must always leave bit 7 high, whatever the CPU does in the same cycle. A synchronised edge may never be reported on two cycles in a row. Other behaviour can only be shown by the bench's scenarios: the exact status byte after each sequence of operations, the bidirectional rule that keeps or clears interrupt A depending on the other buffer's state, the bits that en_wr ignores, events that the current mode does not honour, and the timing of a_oe against the acknowledge pulse.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  localparam int STAT_W    = 8;
  localparam int POS_OBF_A = 7;
  localparam int POS_EN_AK = 6;
  localparam int POS_IBF_A = 5;
  localparam int POS_EN_SA = 4;
  localparam int POS_IRQ_A = 3;
  localparam int POS_EN_B  = 2;
  localparam int POS_BUF_B = 1;
  localparam int POS_IRQ_B = 0;

  typedef enum logic [1:0] {
    AM_PLAIN = 2'd0,
    AM_HSK   = 2'd1,
    AM_BIDI  = 2'd2,
    AM_BIDI2 = 2'd3
  } a_mode_e;

  function automatic logic is_bidi(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic is_hsk(input logic [1:0] m);
    return m == AM_HSK;
  endfunction
endpackage

// File: rtl/hsk_sync_edge.sv
module hsk_sync_edge #(
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] line_in,
  output logic [LANES-1:0] level,
  output logic [LANES-1:0] rise
);
  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh <= '0;
      end else begin
        sh <= {sh[STAGES-1:0], line_in[g]};
      end
    end
    assign level[g] = sh[LAST];
    assign rise[g]  = sh[LAST] & ~sh[STAGES];

    // R9
    single_event_chk: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> !rise[g]);
  end
endmodule

// File: rtl/hsk_grp_a.sv
module hsk_grp_a
  import hsk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    a_mode,
  input  logic          a_dir_in,
  input  logic          stb_rise,
  input  logic          ack_rise,
  input  logic [DW-1:0] pa_in,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          en_wr,
  input  logic [2:0]    en_sel,
  input  logic          en_val,
  output logic          obf_n_q,
  output logic          en_ack_q,
  output logic          ibf_q,
  output logic          en_stb_q,
  output logic          intr_q,
  output logic [DW-1:0] a_in_q
);
  logic bidi, in_ok, out_ok;
  logic stb_ev, ack_ev, rd_ev, wr_ev;
  logic intr_set, intr_clr;

  assign bidi   = is_bidi(a_mode);
  assign in_ok  = bidi | (is_hsk(a_mode) & a_dir_in);
  assign out_ok = bidi | (is_hsk(a_mode) & ~a_dir_in);
  assign stb_ev = stb_rise & in_ok;
  assign ack_ev = ack_rise & out_ok;
  assign rd_ev  = cpu_rd & in_ok;
  assign wr_ev  = cpu_wr & out_ok;

  assign intr_set = (stb_ev & en_stb_q) | (ack_ev & en_ack_q);
  assign intr_clr = (rd_ev & ~(bidi & ~obf_n_q))
                  | (wr_ev & (~bidi | ~ibf_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      obf_n_q  <= 1'b1;
      ibf_q    <= 1'b0;
      intr_q   <= 1'b0;
      en_ack_q <= 1'b0;
      en_stb_q <= 1'b0;
      a_in_q   <= '0;
    end else begin
      if (ack_ev)      obf_n_q <= 1'b1;
      else if (wr_ev)  obf_n_q <= 1'b0;

      if (stb_ev)      ibf_q <= 1'b1;
      else if (rd_ev)  ibf_q <= 1'b0;

      if (intr_set)      intr_q <= 1'b1;
      else if (intr_clr) intr_q <= 1'b0;

      if (stb_ev) a_in_q <= pa_in;

      if (en_wr && en_sel == 3'(POS_EN_AK)) en_ack_q <= en_val;
      if (en_wr && en_sel == 3'(POS_EN_SA)) en_stb_q <= en_val;
    end
  end

  // R3
  ibf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf_q) |-> $past(stb_ev));
  // R3
  intr_a_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_q) |-> $past((stb_ev && en_stb_q) || (ack_ev && en_ack_q)));
  // R5
  rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ev && !stb_ev) |=> !ibf_q);
  // R6
  wr_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ev && !ack_ev) |=> !obf_n_q);
  // R10
  ack_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ack_ev |=> obf_n_q);
endmodule

// File: rtl/hsk_grp_b.sv
module hsk_grp_b
  import hsk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          b_hs,
  input  logic          b_dir_in,
  input  logic          stb_rise,
  input  logic          ack_rise,
  input  logic [DW-1:0] pb_in,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          en_wr,
  input  logic [2:0]    en_sel,
  input  logic          en_val,
  output logic          en_q,
  output logic          buf_q,
  output logic          intr_q,
  output logic [DW-1:0] b_in_q
);
  logic in_ok, out_ok, set_ev, clr_ev, stb_ev;

  assign in_ok  = b_hs & b_dir_in;
  assign out_ok = b_hs & ~b_dir_in;
  assign stb_ev = stb_rise & in_ok;
  assign set_ev = stb_ev | (ack_rise & out_ok);
  assign clr_ev = (cpu_rd & in_ok) | (cpu_wr & out_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      buf_q  <= 1'b0;
      intr_q <= 1'b0;
      b_in_q <= '0;
    end else begin
      if (set_ev) begin
        buf_q <= 1'b1;
        if (en_q) intr_q <= 1'b1;
      end else if (clr_ev) begin
        buf_q  <= 1'b0;
        intr_q <= 1'b0;
      end
      if (stb_ev) b_in_q <= pb_in;
      if (en_wr && en_sel == 3'(POS_EN_B)) en_q <= en_val;
    end
  end

  // R4
  intr_b_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_q) |-> $past(set_ev && en_q));
  // R8
  clr_b_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ev && !set_ev) |=> (!buf_q && !intr_q));
  // R10
  set_b_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> buf_q);
endmodule

// File: rtl/hsk_port_ctrl.sv
module hsk_port_ctrl
  import hsk_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    a_mode,
  input  logic          a_dir_in,
  input  logic          b_hs,
  input  logic          b_dir_in,
  input  logic          stb_a,
  input  logic          ack_a,
  input  logic          stb_b,
  input  logic          ack_b,
  input  logic [DW-1:0] pa_in,
  input  logic [DW-1:0] pb_in,
  input  logic          cpu_rd_a,
  input  logic          cpu_wr_a,
  input  logic          cpu_rd_b,
  input  logic          cpu_wr_b,
  input  logic          en_wr,
  input  logic [2:0]    en_sel,
  input  logic          en_val,
  output logic [7:0]    stat_c,
  output logic [DW-1:0] a_in_q,
  output logic [DW-1:0] b_in_q,
  output logic          irq_a,
  output logic          irq_b,
  output logic          a_oe
);
  localparam int LANES = 4;
  localparam int L_STB_A = 0;
  localparam int L_ACK_A = 1;
  localparam int L_STB_B = 2;
  localparam int L_ACK_B = 3;

  logic [LANES-1:0] lvl, rise;
  logic obf_n, en_ak, ibf, en_sa, intr_a, en_b, buf_b, intr_b;

  hsk_sync_edge #(.LANES(LANES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst),
    .line_in({ack_b, stb_b, ack_a, stb_a}),
    .level(lvl), .rise(rise)
  );

  hsk_grp_a #(.DW(DW)) grp_a_i (
    .clk(clk), .rst(rst), .a_mode(a_mode), .a_dir_in(a_dir_in),
    .stb_rise(rise[L_STB_A]), .ack_rise(rise[L_ACK_A]), .pa_in(pa_in),
    .cpu_rd(cpu_rd_a), .cpu_wr(cpu_wr_a),
    .en_wr(en_wr), .en_sel(en_sel), .en_val(en_val),
    .obf_n_q(obf_n), .en_ack_q(en_ak), .ibf_q(ibf), .en_stb_q(en_sa),
    .intr_q(intr_a), .a_in_q(a_in_q)
  );

  hsk_grp_b #(.DW(DW)) grp_b_i (
    .clk(clk), .rst(rst), .b_hs(b_hs), .b_dir_in(b_dir_in),
    .stb_rise(rise[L_STB_B]), .ack_rise(rise[L_ACK_B]), .pb_in(pb_in),
    .cpu_rd(cpu_rd_b), .cpu_wr(cpu_wr_b),
    .en_wr(en_wr), .en_sel(en_sel), .en_val(en_val),
    .en_q(en_b), .buf_q(buf_b), .intr_q(intr_b), .b_in_q(b_in_q)
  );

  always_comb begin
    stat_c = '0;
    stat_c[POS_OBF_A] = obf_n;
    stat_c[POS_EN_AK] = en_ak;
    stat_c[POS_IBF_A] = ibf;
    stat_c[POS_EN_SA] = en_sa;
    stat_c[POS_IRQ_A] = intr_a;
    stat_c[POS_EN_B]  = en_b;
    stat_c[POS_BUF_B] = buf_b;
    stat_c[POS_IRQ_B] = intr_b;
  end

  assign irq_a = intr_a;
  assign irq_b = intr_b;

  always_ff @(posedge clk) begin
    if (rst) a_oe <= 1'b0;
    else     a_oe <= is_bidi(a_mode) ? lvl[L_ACK_A] : ~a_dir_in;
  end

  // R2
  en_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (en_wr && en_sel != 3'd6 && en_sel != 3'd4 && en_sel != 3'd2)
      |=> $stable({en_ak, en_sa, en_b}));
  // R7
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (is_bidi(a_mode) && $stable(a_mode)) |=> (a_oe == $past(lvl[L_ACK_A])));
endmodule

// File: tb/hsk_port_ctrl_tb.sv
module hsk_port_ctrl_tb_top;
  localparam int DW = 8;
  localparam logic [3:0] OP_MODE = 4'd0, OP_EN = 4'd1, OP_STB_A = 4'd2,
    OP_ACK_A = 4'd3, OP_STB_B = 4'd4, OP_ACK_B = 4'd5, OP_RD_A = 4'd6,
    OP_WR_A = 4'd7, OP_RD_B = 4'd8, OP_WR_B = 4'd9;
  localparam int NV = 36;
  // {op, data, expected status, expected holding register}
  localparam logic [27:0] VEC [NV] = '{
    {OP_MODE, 8'h1D, 8'h80, 8'h00}, {OP_STB_A, 8'h3C, 8'hA0, 8'h3C},
    {OP_RD_A, 8'h00, 8'h80, 8'h00}, {OP_EN, 8'h09, 8'h90, 8'h00},
    {OP_STB_A, 8'h5A, 8'hB8, 8'h5A}, {OP_RD_A, 8'h00, 8'h90, 8'h00},
    {OP_STB_B, 8'hC3, 8'h92, 8'hC3}, {OP_EN, 8'h05, 8'h96, 8'h00},
    {OP_RD_B, 8'h00, 8'h94, 8'h00}, {OP_STB_B, 8'h11, 8'h97, 8'h11},
    {OP_RD_B, 8'h00, 8'h94, 8'h00}, {OP_MODE, 8'h09, 8'h94, 8'h00},
    {OP_STB_A, 8'h77, 8'h94, 8'h5A}, {OP_WR_A, 8'h00, 8'h14, 8'h00},
    {OP_EN, 8'h0D, 8'h54, 8'h00}, {OP_ACK_A, 8'h00, 8'hDC, 8'h00},
    {OP_WR_A, 8'h00, 8'h54, 8'h00}, {OP_ACK_A, 8'h00, 8'hDC, 8'h00},
    {OP_WR_B, 8'h00, 8'hDC, 8'h00}, {OP_ACK_B, 8'h00, 8'hDF, 8'h00},
    {OP_WR_B, 8'h00, 8'hDC, 8'h00}, {OP_MODE, 8'h0A, 8'hDC, 8'h00},
    {OP_WR_A, 8'h00, 8'h54, 8'h00}, {OP_STB_A, 8'hA5, 8'h7C, 8'hA5},
    {OP_RD_A, 8'h00, 8'h5C, 8'h00}, {OP_ACK_A, 8'h00, 8'hDC, 8'h00},
    {OP_WR_A, 8'h00, 8'h54, 8'h00}, {OP_STB_A, 8'h0F, 8'h7C, 8'h0F},
    {OP_WR_A, 8'h00, 8'h7C, 8'h00}, {OP_RD_A, 8'h00, 8'h5C, 8'h00},
    {OP_ACK_A, 8'h00, 8'hDC, 8'h00}, {OP_RD_A, 8'h00, 8'hD4, 8'h00},
    {OP_EN, 8'h0C, 8'h94, 8'h00}, {OP_ACK_A, 8'h00, 8'h94, 8'h00},
    {OP_EN, 8'h0F, 8'h94, 8'h00}, {OP_EN, 8'h03, 8'h94, 8'h00}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] a_mode = '0;
  logic a_dir_in = 1'b1, b_hs = 1'b0, b_dir_in = 1'b1;
  logic stb_a = 0, ack_a = 0, stb_b = 0, ack_b = 0;
  logic [DW-1:0] pa_in = '0, pb_in = '0;
  logic cpu_rd_a = 0, cpu_wr_a = 0, cpu_rd_b = 0, cpu_wr_b = 0;
  logic en_wr = 0, en_val = 0;
  logic [2:0] en_sel = '0;
  logic [7:0] stat_c;
  logic [DW-1:0] a_in_q, b_in_q;
  logic irq_a, irq_b, a_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hsk_port_ctrl #(.DW(DW), .SYNC_STAGES(2)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_line(input logic [3:0] op, input logic [7:0] d);
    @(negedge clk);
    pa_in = d; pb_in = d;
    case (op)
      OP_STB_A: stb_a = 1;
      OP_ACK_A: ack_a = 1;
      OP_STB_B: stb_b = 1;
      default:  ack_b = 1;
    endcase
    repeat (4) @(negedge clk);
    stb_a = 0; ack_a = 0; stb_b = 0; ack_b = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] d);
    case (op)
      OP_MODE: begin
        @(negedge clk);
        a_mode = d[1:0]; a_dir_in = d[2]; b_hs = d[3]; b_dir_in = d[4];
        @(negedge clk);
      end
      OP_STB_A, OP_ACK_A, OP_STB_B, OP_ACK_B: pulse_line(op, d);
      default: begin
        @(negedge clk);
        case (op)
          OP_EN:   begin en_wr = 1; en_sel = d[3:1]; en_val = d[0]; end
          OP_RD_A: cpu_rd_a = 1;
          OP_WR_A: cpu_wr_a = 1;
          OP_RD_B: cpu_rd_b = 1;
          default: cpu_wr_b = 1;
        endcase
        @(negedge clk);
        en_wr = 0; cpu_rd_a = 0; cpu_wr_a = 0; cpu_rd_b = 0; cpu_wr_b = 0;
      end
    endcase
  endtask

  function automatic string op_req(input logic [3:0] op);
    case (op)
      OP_EN:    return "R2";
      OP_STB_A: return "R3";
      OP_STB_B: return "R4";
      OP_RD_A:  return "R5";
      OP_WR_A:  return "R6";
      OP_ACK_A: return "R7";
      OP_MODE:  return "R11";
      default:  return "R8";
    endcase
  endfunction

  task automatic check_reset();
    chk("R1 stat", 32'(stat_c), 32'h80);
    chk("R1 a_in", 32'(a_in_q), 32'h0);
    chk("R1 b_in", 32'(b_in_q), 32'h0);
    chk("R1 irq", 32'({irq_a, irq_b}), 32'h0);
    chk("R1 a_oe", 32'(a_oe), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check_reset();
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      op = VEC[i][27:24];
      do_op(op, VEC[i][23:16]);
      chk(op_req(op), 32'(stat_c), 32'(VEC[i][15:8]));
      chk("R12", 32'({irq_a, irq_b}), 32'({VEC[i][11], VEC[i][8]}));
      if (op == OP_STB_A) chk("R3 data", 32'(a_in_q), 32'(VEC[i][7:0]));
      if (op == OP_STB_B) chk("R4 data", 32'(b_in_q), 32'(VEC[i][7:0]));
    end
    // R11: port B output mode ignores strobe B and CPU reads
    do_op(OP_ACK_B, 8'h00);
    chk("R8 ack b", 32'(stat_c), 32'h97);
    do_op(OP_STB_B, 8'hEE);
    chk("R11 stb b data", 32'(b_in_q), 32'h11);
    do_op(OP_RD_B, 8'h00);
    chk("R11 rd b", 32'(stat_c), 32'h97);
    // R1: reset mid-run
    @(negedge clk); rst = 1; a_mode = 2'd0; a_dir_in = 1;
    repeat (2) @(negedge clk); rst = 0; @(negedge clk);
    check_reset();
    // R10: acknowledge and CPU write in the same cycle
    do_op(OP_MODE, 8'h0A);
    do_op(OP_EN, 8'h0D);
    do_op(OP_WR_A, 8'h00);
    chk("R6 wr bidi", 32'(stat_c), 32'h40);
    @(negedge clk); ack_a = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); cpu_wr_a = 1;
    @(negedge clk); cpu_wr_a = 0;
    chk("R10 ack wins", 32'(stat_c), 32'hC8);
    @(negedge clk); ack_a = 0;
    repeat (5) @(negedge clk);
    // R7: output-enable in bidirectional mode
    chk("R7 oe low", 32'(a_oe), 32'h0);
    ack_a = 1;
    repeat (5) @(negedge clk);
    chk("R7 oe during ack", 32'(a_oe), 32'h1);
    ack_a = 0;
    repeat (5) @(negedge clk);
    chk("R7 oe after ack", 32'(a_oe), 32'h0);
    do_op(OP_MODE, 8'h09);
    chk("R7 oe hsk out", 32'(a_oe), 32'h1);
    // R9: long strobe gives one event only
    do_op(OP_MODE, 8'h0D);
    @(negedge clk); pa_in = 8'h99; stb_a = 1;
    repeat (4) @(negedge clk);
    chk("R9 first event", 32'(stat_c), 32'hE8);
    do_op(OP_RD_A, 8'h00);
    repeat (6) @(negedge clk);
    chk("R9 no repeat", 32'(stat_c), 32'hC0);
    chk("R9 data", 32'(a_in_q), 32'h99);
    stb_a = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule